// File: doc/BRIEF.md
# Segmented Multi-Mode Digitizer Controller

This block is the acquisition controller of a four-channel, 8-bit digitizer. It produces a sample tick, either by dividing the on-board clock or by following an external sample strobe. On each tick it routes the four channel samples to one of three destinations, chosen by an acquisition mode.

In continuous mode, every sample goes to an external FIFO, and the host is asked for service through the FIFO's flags. In transient mode, the channel memory is cut into equal segments. Each segment fills as a ring until an event trigger arrives. A programmed number of post-event samples then completes the segment, and capture moves on to the next one. In monitoring mode, nothing is stored: a live register simply tracks the newest sample.

Configuration is written through a four-entry select/data port while acquisition is idle. Acquisition is launched with a start pulse. In continuous and monitoring modes the stop input ends acquisition. In transient mode the stop input acts as the per-segment event trigger.

Top module: `segdig_ctrl`

## Requirements
- R1: After reset, ram_we, fifo_we, done, overrun and srq are low, ram_addr is zero, and acquisition is idle.
- R2: With the internal source selected, sample ticks recur every D+1 clock cycles, where D is the divisor written at select 1.
- R3: Bit 2 of the select-0 word picks the external strobe. Each single-cycle ext_tick pulse then gives exactly one sample, stored one cycle later, and nothing is stored without a pulse.
- R4: In continuous mode (select-0 bits 1:0 = 0), each tick after start asserts fifo_we for one cycle in the next cycle, with wdata holding the four samples (channel 0 in bits 7:0). A stop pulse ends writing.
- R5: A tick that finds fifo_full high writes nothing and sets overrun. Overrun stays set until the next start pulse.
- R6: srq follows fifo_half in continuous mode, and is also high while idle with fifo_empty low. In transient mode, srq equals done.
- R7: In transient mode (bits 1:0 = 1), with segment size 2^L (L written at select 2), writes go to address segment*2^L + offset. Before the event, the offset wraps inside the segment.
- R8: After an event trigger, exactly P further samples are written (P written at select 3; a P of zero counts as one). The next write then lands at offset 0 of the following segment. Triggers during that post-event window are ignored.
- R9: When the last segment completes, done rises with its final write, and no further writes follow. A start pulse clears done and resumes at segment 0, offset 0.
- R10: In monitoring mode (bits 1:0 = 2), live_data takes the samples on every tick, and neither ram_we nor fifo_we is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and on-board sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration select: 0 mode/source, 1 divisor, 2 segment size log2, 3 post count |
| cfg_wdata | input | CFG_W | Configuration data |
| start_trig | input | 1 | Start pulse (arms transient capture) |
| stop_trig | input | 1 | Stop pulse; event trigger in transient mode |
| ext_tick | input | 1 | External sample strobe |
| adc_data | input | NCH*SW | Current samples of all channels |
| fifo_empty | input | 1 | FIFO empty flag |
| fifo_half | input | 1 | FIFO half-full flag |
| fifo_full | input | 1 | FIFO full flag |
| ram_addr | output | ADDR_W | Segment memory address, shared by the channels |
| ram_we | output | 1 | Segment memory write strobe |
| fifo_we | output | 1 | FIFO write strobe |
| wdata | output | NCH*SW | Registered samples for memory or FIFO |
| live_data | output | NCH*SW | On-the-fly sample value in monitoring mode |
| srq | output | 1 | Service request to the host |
| done | output | 1 | All transient segments captured |
| overrun | output | 1 | A sample was dropped on a full FIFO |

## Verification
The assertions assume that configuration registers change only while acquisition is idle. They also assume that start and stop never arrive in the same cycle, and that the external strobe is a single-cycle pulse. The stimulus writes every register before the start pulse and holds each trigger for exactly one cycle. It places event triggers directly after an observed write, so they never coincide with a sample tick. Mode checks come only after a mode has been in force for more than one cycle, so the rule that monitoring mode stays silent is never judged across a mode change.

// File: rtl/segdig_pkg.sv
package segdig_pkg;
  typedef enum logic [1:0] {
    ACQ_CONT  = 2'd0,
    ACQ_TRANS = 2'd1,
    ACQ_MON   = 2'd2
  } acq_mode_e;

  localparam logic [1:0] SEL_MODE = 2'd0;
  localparam logic [1:0] SEL_DIV  = 2'd1;
  localparam logic [1:0] SEL_SEG  = 2'd2;
  localparam logic [1:0] SEL_POST = 2'd3;
endpackage

// File: rtl/segdig_tick_gen.sv
module segdig_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             ext_sel,
  input  logic             ext_tick,
  output logic             int_tick,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign int_tick = (cnt_q >= div);
  assign tick     = ext_sel ? ext_tick : int_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (int_tick) cnt_q <= '0;
    else               cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/segdig_seg_addr.sv
module segdig_seg_addr #(
  parameter int ADDR_W = 19,
  parameter int LG_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              adv,
  input  logic              trig,
  input  logic [LG_W-1:0]   lg,
  input  logic [ADDR_W-1:0] post_len,
  output logic [ADDR_W-1:0] addr,
  output logic              in_post,
  output logic              seg_adv_evt,
  output logic              done_evt
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  function automatic logic [ADDR_W-1:0] off_mask(input logic [LG_W-1:0] l);
    return ~({ADDR_W{1'b1}} << l);
  endfunction

  function automatic logic [ADDR_W-1:0] last_idx(input logic [LG_W-1:0] l);
    return {ADDR_W{1'b1}} >> l;
  endfunction

  logic [ADDR_W-1:0] idx_q, off_q, pcnt_q;
  logic              post_q;
  logic              post_end;

  assign addr        = (idx_q << lg) | off_q;
  assign in_post     = post_q;
  assign post_end    = adv && post_q && (pcnt_q <= ONE);
  assign seg_adv_evt = post_end && (idx_q != last_idx(lg));
  assign done_evt    = post_end && (idx_q == last_idx(lg));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0; off_q <= '0; pcnt_q <= '0; post_q <= 1'b0;
    end else if (restart) begin
      idx_q <= '0; off_q <= '0; pcnt_q <= '0; post_q <= 1'b0;
    end else begin
      if (post_end) begin
        off_q  <= '0;
        post_q <= 1'b0;
        if (seg_adv_evt) idx_q <= idx_q + ONE;
      end else if (adv) begin
        off_q <= (off_q + ONE) & off_mask(lg);
        if (post_q) pcnt_q <= pcnt_q - ONE;
      end
      if (trig && !post_q) begin
        post_q <= 1'b1;
        pcnt_q <= post_len;
      end
    end
  end
endmodule

// File: rtl/segdig_fifo_guard.sv
module segdig_fifo_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic smp,
  input  logic fifo_full,
  output logic push,
  output logic ovf_evt,
  output logic overrun
);
  assign push    = smp && !fifo_full;
  assign ovf_evt = smp && fifo_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       overrun <= 1'b0;
    else if (clear)   overrun <= 1'b0;
    else if (ovf_evt) overrun <= 1'b1;
  end
endmodule

// File: rtl/segdig_ctrl.sv
module segdig_ctrl
  import segdig_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int SW     = 8,
  parameter int ADDR_W = 19,
  parameter int DIV_W  = 16,
  parameter int LG_W   = $clog2(ADDR_W + 1),
  parameter int CFG_W  = (ADDR_W > DIV_W) ? ADDR_W : DIV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              start_trig,
  input  logic              stop_trig,
  input  logic              ext_tick,
  input  logic [NCH*SW-1:0] adc_data,
  input  logic              fifo_empty,
  input  logic              fifo_half,
  input  logic              fifo_full,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_we,
  output logic              fifo_we,
  output logic [NCH*SW-1:0] wdata,
  output logic [NCH*SW-1:0] live_data,
  output logic              srq,
  output logic              done,
  output logic              overrun
);
  localparam int DW = NCH * SW;

  acq_mode_e         mode_q;
  logic              ext_q;
  logic [DIV_W-1:0]  div_q;
  logic [LG_W-1:0]   lg_q;
  logic [ADDR_W-1:0] post_q;
  logic              run_q, done_q;

  logic              tick, int_tick;
  logic              is_cont, is_trans, is_mon;
  logic              smp_ev, tr_adv, tr_trig, cont_smp;
  logic [ADDR_W-1:0] seg_addr_w;
  logic              in_post, seg_adv_evt, seg_done_evt;
  logic              fifo_push, ovf_evt;

  assign is_cont  = (mode_q == ACQ_CONT);
  assign is_trans = (mode_q == ACQ_TRANS);
  assign is_mon   = (mode_q == ACQ_MON);
  assign smp_ev   = run_q && tick;
  assign tr_adv   = smp_ev && is_trans;
  assign tr_trig  = run_q && is_trans && stop_trig;
  assign cont_smp = smp_ev && is_cont;

  segdig_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(div_q), .ext_sel(ext_q),
    .ext_tick(ext_tick), .int_tick(int_tick), .tick(tick)
  );

  segdig_seg_addr #(.ADDR_W(ADDR_W), .LG_W(LG_W)) u_seg (
    .clk(clk), .rst_n(rst_n), .restart(start_trig), .adv(tr_adv),
    .trig(tr_trig), .lg(lg_q), .post_len(post_q), .addr(seg_addr_w),
    .in_post(in_post), .seg_adv_evt(seg_adv_evt), .done_evt(seg_done_evt)
  );

  segdig_fifo_guard u_guard (
    .clk(clk), .rst_n(rst_n), .clear(start_trig), .smp(cont_smp),
    .fifo_full(fifo_full), .push(fifo_push), .ovf_evt(ovf_evt),
    .overrun(overrun)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= ACQ_CONT; ext_q <= 1'b0; div_q <= '0; lg_q <= '0; post_q <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_MODE: begin
          mode_q <= acq_mode_e'(cfg_wdata[1:0]);
          ext_q  <= cfg_wdata[2];
        end
        SEL_DIV:  div_q  <= cfg_wdata[DIV_W-1:0];
        SEL_SEG:  lg_q   <= cfg_wdata[LG_W-1:0];
        default:  post_q <= cfg_wdata[ADDR_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; done_q <= 1'b0;
    end else if (start_trig) begin
      run_q <= 1'b1; done_q <= 1'b0;
    end else if (seg_done_evt) begin
      run_q <= 1'b0; done_q <= 1'b1;
    end else if (stop_trig && !is_trans) begin
      run_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_we <= 1'b0; fifo_we <= 1'b0; ram_addr <= '0;
      wdata <= '0; live_data <= '0;
    end else begin
      ram_we  <= tr_adv;
      fifo_we <= fifo_push;
      if (tr_adv)           ram_addr  <= seg_addr_w;
      if (smp_ev)           wdata     <= adc_data[DW-1:0];
      if (smp_ev && is_mon) live_data <= adc_data[DW-1:0];
    end
  end

  assign done = done_q;
  assign srq  = is_cont ? (fifo_half || (!run_q && !fifo_empty)) : (is_trans && done_q);
endmodule

// File: rtl/segdig_ctrl_chk.sv
module segdig_ctrl_chk
  import segdig_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input acq_mode_e        mode_q,
  input logic [DIV_W-1:0] div_q,
  input logic             int_tick,
  input logic             ovf_evt,
  input logic             overrun,
  input logic             ram_we,
  input logic             fifo_we,
  input logic             done
);
  a_r5_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (overrun && !fifo_we));

  a_r4_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we && fifo_we));

  a_r9_done_halts: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!ram_we && !fifo_we));

  a_r10_mon_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == ACQ_MON) && $past(mode_q == ACQ_MON)) |-> (!ram_we && !fifo_we));

  a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (int_tick && (div_q != '0)) |=> (!int_tick || (div_q == '0)));
endmodule

bind segdig_ctrl segdig_ctrl_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .div_q(div_q),
  .int_tick(int_tick), .ovf_evt(ovf_evt), .overrun(overrun),
  .ram_we(ram_we), .fifo_we(fifo_we), .done(done)
);

// File: tb/segdig_ctrl_tb_top.sv
module segdig_ctrl_tb_top;
  localparam int AW = 6;
  localparam int DV = 8;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = 2'd0;
  logic [CW-1:0] cfg_wdata = '0;
  logic          start_trig = 1'b0, stop_trig = 1'b0, ext_tick = 1'b0;
  logic [31:0]   adc_data = 32'h0;
  logic          fifo_empty = 1'b1, fifo_half = 1'b0, fifo_full = 1'b0;
  logic [AW-1:0] ram_addr;
  logic          ram_we, fifo_we, srq, done, overrun;
  logic [31:0]   wdata, live_data;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  segdig_ctrl #(.ADDR_W(AW), .DIV_W(DV)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .start_trig(start_trig), .stop_trig(stop_trig),
    .ext_tick(ext_tick), .adc_data(adc_data), .fifo_empty(fifo_empty),
    .fifo_half(fifo_half), .fifo_full(fifo_full), .ram_addr(ram_addr),
    .ram_we(ram_we), .fifo_we(fifo_we), .wdata(wdata),
    .live_data(live_data), .srq(srq), .done(done), .overrun(overrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [CW-1:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_start();
    start_trig = 1'b1;
    @(negedge clk);
    start_trig = 1'b0;
  endtask

  task automatic pulse_stop();
    stop_trig = 1'b1;
    @(negedge clk);
    stop_trig = 1'b0;
  endtask

  task automatic wait_ram(output logic [AW-1:0] a, output logic [31:0] d);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!ram_we && n < 200);
    if (!ram_we) chk("R7 ram write timeout", 32'd0, 32'd1);
    a = ram_addr; d = wdata;
  endtask

  task automatic wait_fifo(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!fifo_we && gap < 200);
    if (!fifo_we) chk("R4 fifo write timeout", 32'd0, 32'd1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 ram_we", 32'(ram_we), 32'd0);
    chk("R1 fifo_we", 32'(fifo_we), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 overrun", 32'(overrun), 32'd0);
    chk("R1 srq", 32'(srq), 32'd0);
    chk("R1 ram_addr", 32'(ram_addr), 32'd0);
  endtask

  task automatic t_continuous();
    int g;
    int seen;
    cfg(2'd0, 8'd0);
    cfg(2'd1, 8'd2);
    adc_data = 32'hA1B2C3D4;
    pulse_start();
    wait_fifo(g);
    chk("R4 fifo data", wdata, 32'hA1B2C3D4);
    adc_data = 32'h11223344;
    wait_fifo(g);
    chk("R2 tick spacing div=2", 32'(g), 32'd3);
    chk("R4 fifo data changed", wdata, 32'h11223344);
    wait_fifo(g);
    chk("R2 tick spacing repeat", 32'(g), 32'd3);
    fifo_half = 1'b1; #1;
    chk("R6 srq on half", 32'(srq), 32'd1);
    fifo_half = 1'b0; #1;
    chk("R6 srq clear", 32'(srq), 32'd0);
    @(negedge clk);
    pulse_stop();
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (fifo_we) seen++;
    end
    chk("R4 stop halts fifo writes", 32'(seen), 32'd0);
    fifo_empty = 1'b0; #1;
    chk("R6 srq idle residual", 32'(srq), 32'd1);
    fifo_empty = 1'b1; #1;
    chk("R6 srq idle empty", 32'(srq), 32'd0);
  endtask

  task automatic t_overrun();
    int g;
    int seen;
    cfg(2'd1, 8'd1);
    pulse_start();
    fifo_full = 1'b1;
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (fifo_we) seen++;
    end
    chk("R5 no write while full", 32'(seen), 32'd0);
    chk("R5 overrun set", 32'(overrun), 32'd1);
    fifo_full = 1'b0;
    wait_fifo(g);
    chk("R5 writes resume", 32'(fifo_we), 32'd1);
    chk("R5 overrun sticky", 32'(overrun), 32'd1);
    pulse_stop();
    pulse_start();
    chk("R5 start clears overrun", 32'(overrun), 32'd0);
    pulse_stop();
  endtask

  task automatic t_ext_clock();
    int seen;
    cfg(2'd0, 8'h04);
    adc_data = 32'h5A5A0F0F;
    pulse_start();
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (fifo_we) seen++;
    end
    chk("R3 no strobe no write", 32'(seen), 32'd0);
    ext_tick = 1'b1;
    @(negedge clk);
    ext_tick = 1'b0;
    chk("R3 strobe write", 32'(fifo_we), 32'd1);
    chk("R3 strobe data", wdata, 32'h5A5A0F0F);
    @(negedge clk);
    chk("R3 single write", 32'(fifo_we), 32'd0);
    pulse_stop();
  endtask

  task automatic t_transient();
    logic [AW-1:0] a;
    logic [31:0]   d;
    int seen;
    cfg(2'd0, 8'd1);
    cfg(2'd1, 8'd3);
    cfg(2'd2, 8'd4);
    cfg(2'd3, 8'd3);
    adc_data = 32'hCAFE0123;
    pulse_start();
    for (int i = 0; i < 20; i++) begin
      wait_ram(a, d);
      chk("R7 ring offset seg0", 32'(a), 32'(i % 16));
    end
    chk("R7 ram data", d, 32'hCAFE0123);
    pulse_stop();
    for (int j = 0; j < 3; j++) begin
      wait_ram(a, d);
      chk("R8 post sample seg0", 32'(a), 32'(4 + j));
    end
    for (int s = 1; s < 4; s++) begin
      for (int i = 0; i < 3; i++) begin
        wait_ram(a, d);
        chk("R8 next segment pre", 32'(a), 32'(s * 16 + i));
      end
      pulse_stop();
      for (int j = 0; j < 3; j++) begin
        wait_ram(a, d);
        chk("R8 post sample", 32'(a), 32'(s * 16 + 3 + j));
        if (s == 1 && j == 0) pulse_stop();
      end
    end
    chk("R9 done with last write", 32'(done), 32'd1);
    chk("R6 srq equals done", 32'(srq), 32'd1);
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (ram_we) seen++;
    end
    chk("R9 no write after done", 32'(seen), 32'd0);
  endtask

  task automatic t_restart_post0();
    logic [AW-1:0] a;
    logic [31:0]   d;
    cfg(2'd3, 8'd0);
    pulse_start();
    chk("R9 start clears done", 32'(done), 32'd0);
    wait_ram(a, d);
    chk("R9 restart address", 32'(a), 32'd0);
    pulse_stop();
    wait_ram(a, d);
    chk("R8 post zero single sample", 32'(a), 32'd1);
    wait_ram(a, d);
    chk("R8 post zero next segment", 32'(a), 32'd16);
  endtask

  task automatic t_monitor();
    int seen;
    cfg(2'd0, 8'd2);
    cfg(2'd1, 8'd2);
    adc_data = 32'h0BADF00D;
    pulse_start();
    seen = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (fifo_we || ram_we) seen++;
    end
    chk("R10 live value", live_data, 32'h0BADF00D);
    adc_data = 32'h600DCAFE;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (fifo_we || ram_we) seen++;
    end
    chk("R10 live tracks", live_data, 32'h600DCAFE);
    chk("R10 no writes", 32'(seen), 32'd0);
    pulse_stop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_continuous();
    t_overrun();
    t_ext_clock();
    t_transient();
    t_restart_post0();
    t_monitor();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk("watchdog", 32'd0, 32'd1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule